// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block runs one sampling transaction at a time against an eight-input, 12-bit successive-approximation converter. The converter's serial port is used in its self-clocked conversion mode. A request carries a channel number, a unipolar/bipolar choice, a single-ended/differential choice and two power-down bits. From these the sequencer builds an eight-bit command and sends it out most significant bit first, using a serial clock derived from the system clock.

Once the command has gone out, the serial clock stays low. The block then watches the converter's busy/done strobe, which it brings in through a two-flop synchronizer. When the strobe shows that the conversion has finished, the block runs sixteen more clock pulses. From these it takes the 12-bit result, most significant bit first, drops the trailing fill bits, releases chip select and issues a one-cycle result pulse. If the strobe does not report completion within a parameterized number of system cycles, the block gives up. It releases chip select and raises a sticky timeout flag, which the next accepted request clears. `TMO_CYC` should cover at least 10 µs. `DIV_HALF` (at least 2) should be large enough that the command bits give the converter at least 1.5 µs of acquisition time.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, and whenever idle, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_din` is 0, `req_ready` is 1, and `res_valid` and `res_timeout` are 0.
- R2: A request is taken only while `req_ready` is 1. `req_ready` is 0 from acceptance until the transaction ends, and a `req_valid` pulse during that time starts no further frame and does not alter the command being sent.
- R3: The command is sent on `adc_din` most significant bit first as {1, channel[2:0], unipolar, single, pd[1:0]}, so the leading bit is always 1. `adc_din` changes only when `adc_sclk` falls and is held while `adc_sclk` is high.
- R4: `adc_sclk` has a period of 2·DIV_HALF system clocks, with high and low phases of DIV_HALF clocks each.
- R5: After the eighth command pulse, `adc_sclk` stays low for as long as the strobe is low (busy).
- R6: After the synchronized strobe has been seen low and then high, exactly 16 more `adc_sclk` pulses are issued, giving 24 pulses per frame. `adc_dout` is sampled on the rising edges of the 2nd to the 13th of those pulses, B11 first, and the remaining three pulses carry fill bits that are ignored.
- R7: At the end of a completed frame, `adc_cs_n` returns to 1 in the same cycle that `res_valid` is 1 for exactly one cycle, with `res_data` holding the 12-bit result.
- R8: If the transaction has not reached its readback within TMO_CYC cycles of the end of the command, `res_timeout` becomes 1 and `adc_cs_n` returns to 1. No readback pulses are issued, `res_valid` stays 0, and the block becomes ready again.
- R9: `res_timeout` stays 1 until a request is accepted, and is 0 from the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Sample request |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_chan | input | 3 | Channel select |
| req_unipolar | input | 1 | 1 = unipolar input range |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_pd | input | 2 | Power-down bits sent with the command |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_din | output | 1 | Serial command data to converter |
| adc_dout | input | 1 | Serial result data from converter |
| adc_sstrb | input | 1 | Converter busy/done strobe, low while converting |
| res_valid | output | 1 | One-cycle pulse with a new result |
| res_data | output | 12 | Last completed result |
| res_timeout | output | 1 | Sticky conversion timeout flag |

## Verification
The hardest situation to reach is the boundary of the timeout window. Near that boundary, a strobe that rises only a few cycles before the limit must still lead to a full readback, while one a little later must abort the frame. The bench contains a reactive converter model whose busy time is set per request. Directed requests place this time just inside and just outside the limit, between runs of random requests. Each timeout is followed by an idle wait, so the flag's persistence is checked before the next request clears it. A request pulse is also driven into the middle of a busy frame.

// File: rtl/adc_host_pkg.sv
// Package: shared types and constants for the serial ADC host sequencer.
// Assumes: a 12-bit converter taking an 8-bit command, 24 clocks per frame.
package adc_host_pkg;

    localparam int CTRL_BITS    = 8;
    localparam int RES_BITS     = 12;
    localparam int READ_PULSES  = 16;
    localparam int FRAME_PULSES = CTRL_BITS + READ_PULSES;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CTRL,
        SEQ_CONV,
        SEQ_READ,
        SEQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic       start;
        logic [2:0] chan;
        logic       unipolar;
        logic       single;
        logic [1:0] pd;
    } ctrl_byte_t;

    // Build the command word; the leading bit is always set.
    function automatic logic [CTRL_BITS-1:0] pack_ctrl(
        input logic [2:0] chan,
        input logic       unipolar,
        input logic       single,
        input logic [1:0] pd
    );
        ctrl_byte_t c;
        c.start    = 1'b1;
        c.chan     = chan;
        c.unipolar = unipolar;
        c.single   = single;
        c.pd       = pd;
        return c;
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
// Module: serial clock generator.
// Produces a square clock of 2*DIV_HALF system cycles while run is high,
// and flags the system edge at which the serial clock rises or falls.
// Assumes: DIV_HALF >= 2; the clock is forced low whenever run is low.
module adc_sclk_gen #(
    parameter int DIV_HALF = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          wrap;

    // Half-period boundary detection and edge events.
    always_comb begin
        wrap     = run && (cnt_q == CW'(DIV_HALF - 1));
        rise_evt = wrap && !sclk_q;
        fall_evt = wrap && sclk_q;
    end

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk = sclk_q;

endmodule

// File: rtl/adc_strb_sync.sv
// Module: synchronizer for the converter's busy/done strobe.
// Assumes: the strobe idles high (done); flops reset to that level.
module adc_strb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_async,
    output logic strb_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= strb_async;
            end
        end else begin : g_multi
            // Shift the strobe through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], strb_async};
            end
        end
    endgenerate

    assign strb_sync = chain_q[STAGES-1];

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: transaction sequencer.
// Sends the command, waits on the synchronized strobe with a timeout,
// then reads back the result on the serial clock events from the generator.
// Assumes: rise_evt/fall_evt mark the system edge at which sclk changes;
// DIN is updated on falls, DOUT sampled on rises.
module adc_seq_fsm
    import adc_host_pkg::*;
#(
    parameter int TMO_CYC = 2500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_chan,
    input  logic                req_unipolar,
    input  logic                req_single,
    input  logic [1:0]          req_pd,
    input  logic                rise_evt,
    input  logic                fall_evt,
    input  logic                strb_s,
    input  logic                adc_dout,
    output logic                sclk_run,
    output logic                adc_cs_n,
    output logic                adc_din,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic                res_timeout
);

    localparam int ECW = $clog2(READ_PULSES + 1);
    localparam int TW  = $clog2(TMO_CYC + 1);

    seq_state_t            state;
    logic [CTRL_BITS-1:0]  tx_q;
    logic [CTRL_BITS-1:0]  ctrl_w;
    logic [ECW-1:0]        edge_cnt;
    logic [RES_BITS-1:0]   rx_q;
    logic [RES_BITS-1:0]   res_q;
    logic [TW-1:0]         tmo_cnt;
    logic                  seen_low;
    logic                  cs_n_q;
    logic                  din_q;
    logic                  valid_q;
    logic                  tmo_q;
    logic                  in_window;

    // Command word and readback sampling window.
    always_comb begin
        ctrl_w    = pack_ctrl(req_chan, req_unipolar, req_single, req_pd);
        in_window = (edge_cnt >= ECW'(1)) && (edge_cnt <= ECW'(RES_BITS));
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            tx_q     <= '0;
            edge_cnt <= '0;
            rx_q     <= '0;
            res_q    <= '0;
            tmo_cnt  <= '0;
            seen_low <= 1'b0;
            cs_n_q   <= 1'b1;
            din_q    <= 1'b0;
            valid_q  <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        din_q    <= ctrl_w[CTRL_BITS-1];
                        tx_q     <= {ctrl_w[CTRL_BITS-2:0], 1'b0};
                        cs_n_q   <= 1'b0;
                        tmo_q    <= 1'b0;
                        edge_cnt <= '0;
                        state    <= SEQ_CTRL;
                    end
                end
                SEQ_CTRL: begin
                    if (rise_evt) edge_cnt <= edge_cnt + 1'b1;
                    if (fall_evt) begin
                        if (edge_cnt == ECW'(CTRL_BITS)) begin
                            din_q    <= 1'b0;
                            tmo_cnt  <= '0;
                            seen_low <= 1'b0;
                            state    <= SEQ_CONV;
                        end else begin
                            din_q <= tx_q[CTRL_BITS-1];
                            tx_q  <= {tx_q[CTRL_BITS-2:0], 1'b0};
                        end
                    end
                end
                SEQ_CONV: begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                    if (!strb_s) seen_low <= 1'b1;
                    if (seen_low && strb_s) begin
                        edge_cnt <= '0;
                        state    <= SEQ_READ;
                    end else if (tmo_cnt == TW'(TMO_CYC - 1)) begin
                        tmo_q  <= 1'b1;
                        cs_n_q <= 1'b1;
                        state  <= SEQ_IDLE;
                    end
                end
                SEQ_READ: begin
                    if (rise_evt) begin
                        edge_cnt <= edge_cnt + 1'b1;
                        if (in_window) rx_q <= {rx_q[RES_BITS-2:0], adc_dout};
                    end
                    if (fall_evt && edge_cnt == ECW'(READ_PULSES)) begin
                        cs_n_q  <= 1'b1;
                        res_q   <= rx_q;
                        valid_q <= 1'b1;
                        state   <= SEQ_DONE;
                    end
                end
                SEQ_DONE: begin
                    state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign req_ready   = (state == SEQ_IDLE);
    assign sclk_run    = (state == SEQ_CTRL) || (state == SEQ_READ);
    assign adc_cs_n    = cs_n_q;
    assign adc_din     = din_q;
    assign res_valid   = valid_q;
    assign res_data    = res_q;
    assign res_timeout = tmo_q;

endmodule

// File: rtl/adc_host_ctrl.sv
// Module: top of the serial ADC host sequencer.
// Ties the clock generator, strobe synchronizer and sequencer together.
// Assumes: DIV_HALF >= 2, TMO_CYC covers the converter's longest busy time.
module adc_host_ctrl #(
    parameter int DIV_HALF    = 40,
    parameter int TMO_CYC     = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_chan,
    input  logic        req_unipolar,
    input  logic        req_single,
    input  logic [1:0]  req_pd,
    output logic        adc_cs_n,
    output logic        adc_sclk,
    output logic        adc_din,
    input  logic        adc_dout,
    input  logic        adc_sstrb,
    output logic        res_valid,
    output logic [11:0] res_data,
    output logic        res_timeout
);

    logic sclk_run;
    logic rise_evt;
    logic fall_evt;
    logic strb_s;

    adc_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sclk_run),
        .sclk     (adc_sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    adc_strb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb_async (adc_sstrb),
        .strb_sync  (strb_s)
    );

    adc_seq_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_chan     (req_chan),
        .req_unipolar (req_unipolar),
        .req_single   (req_single),
        .req_pd       (req_pd),
        .rise_evt     (rise_evt),
        .fall_evt     (fall_evt),
        .strb_s       (strb_s),
        .adc_dout     (adc_dout),
        .sclk_run     (sclk_run),
        .adc_cs_n     (adc_cs_n),
        .adc_din      (adc_din),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_timeout  (res_timeout)
    );

endmodule

// File: rtl/adc_host_ctrl_chk.sv
// Module: port-level protocol checker, bound to adc_host_ctrl.
// Assumes: synchronous active-low reset; all checks disabled during reset.
module adc_host_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_din,
    input logic adc_sstrb,
    input logic res_valid,
    input logic res_timeout
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (adc_cs_n && !adc_sclk));

    // R2
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> !req_ready);

    // R3
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk && $past(adc_sclk)) |-> $stable(adc_din));

    // R5
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && !adc_sstrb && !$past(adc_sstrb) && !$past(adc_sstrb, 2))
        |-> !adc_sclk);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R7
    valid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (adc_cs_n && !res_timeout));

    // R8
    tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_timeout) |-> adc_cs_n);

    // R9
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_timeout && !(req_valid && req_ready)) |=> res_timeout);

    // R9
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !res_timeout);

endmodule

bind adc_host_ctrl adc_host_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .adc_din     (adc_din),
    .adc_sstrb   (adc_sstrb),
    .res_valid   (res_valid),
    .res_timeout (res_timeout)
);

// File: tb/sim_adc_host_ctrl.sv
// Bench: reactive converter model plus random and directed requests.
module sim_adc_host_ctrl;

    localparam int DIV  = 4;
    localparam int TMO  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_chan = '0;
    logic        req_unipolar = 1'b0;
    logic        req_single = 1'b0;
    logic [1:0]  req_pd = '0;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_din;
    logic        adc_dout = 1'b0;
    logic        adc_sstrb = 1'b1;
    logic        res_valid;
    logic [11:0] res_data;
    logic        res_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    adc_host_ctrl #(.DIV_HALF(DIV), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_unipolar(req_unipolar), .req_single(req_single),
        .req_pd(req_pd), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .adc_dout(adc_dout), .adc_sstrb(adc_sstrb), .res_valid(res_valid),
        .res_data(res_data), .res_timeout(res_timeout)
    );

    always #2 clk = !clk;

    // Converter model state
    logic [11:0] conv_val = '0;
    int          conv_len = 20;
    int          conv_timer = 0;
    logic        m_sclk_q = 1'b0;
    logic        m_cs_q = 1'b1;
    int          rise_cnt = 0;
    int          fall_cnt = 0;
    logic [7:0]  ctrl_cap = '0;
    logic        read_armed = 1'b0;
    int          rd_ptr = 0;
    int          cyc = 0;
    int          t_r1 = 0;
    int          t_r8 = 0;
    int          last_pulses = 0;
    logic [7:0]  last_ctrl = '0;
    int          last_gap = 0;
    int          frames = 0;
    int          viol = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reactive converter model; sees the design's outputs one edge late.
    always @(posedge clk) begin
        m_sclk_q <= adc_sclk;
        m_cs_q   <= adc_cs_n;
        if (rst_n && !adc_sstrb && adc_sclk && !adc_cs_n) viol <= viol + 1;
        if (conv_timer > 0) begin
            conv_timer <= conv_timer - 1;
            if (conv_timer == 1) begin
                adc_sstrb  <= 1'b1;
                read_armed <= 1'b1;
                rd_ptr     <= 0;
            end
        end
        if (!adc_cs_n && m_cs_q) begin
            rise_cnt   <= 0;
            fall_cnt   <= 0;
            read_armed <= 1'b0;
        end
        if (!adc_cs_n && adc_sclk && !m_sclk_q) begin
            rise_cnt <= rise_cnt + 1;
            if (rise_cnt == 0) t_r1 <= cyc;
            if (rise_cnt == 7) t_r8 <= cyc;
            if (rise_cnt < 8) ctrl_cap <= {ctrl_cap[6:0], adc_din};
        end
        if (!adc_cs_n && !adc_sclk && m_sclk_q) begin
            fall_cnt <= fall_cnt + 1;
            if (fall_cnt == 7) begin
                adc_sstrb  <= 1'b0;
                conv_timer <= conv_len;
            end
            if (read_armed) begin
                adc_dout <= (rd_ptr < 12) ? conv_val[11 - rd_ptr] : 1'b0;
                rd_ptr   <= rd_ptr + 1;
            end
        end
        if (adc_cs_n && !m_cs_q) begin
            last_pulses <= rise_cnt;
            last_ctrl   <= ctrl_cap;
            last_gap    <= t_r8 - t_r1;
            read_armed  <= 1'b0;
            adc_dout    <= 1'b0;
            frames      <= frames + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_frame(input logic [2:0] ch, input logic uni, input logic sgl,
                            input logic [1:0] pd, input logic [11:0] val,
                            input int clen, input bit poke);
        int f0;
        int vcnt;
        int n;
        logic [11:0] got;
        logic [7:0]  exp_ctrl;
        bit exp_to;
        exp_to   = (clen + 3 > TMO);
        exp_ctrl = {1'b1, ch, uni, sgl, pd};
        conv_val = val;
        conv_len = clen;
        while (!req_ready) @(negedge clk);
        f0 = frames;
        req_chan = ch; req_unipolar = uni; req_single = sgl; req_pd = pd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(res_timeout == 1'b0, "R9 flag cleared on accept", res_timeout, 0);
        check(!req_ready && !adc_cs_n, "R2 busy after accept", {req_ready, adc_cs_n}, 0);
        vcnt = 0; n = 0; got = '0;
        while (frames == f0 && n < 5000) begin
            @(negedge clk);
            if (poke && n == 20) begin
                req_valid = 1'b1;
                req_chan  = ~ch;
                req_pd    = ~pd;
            end
            if (poke && n == 22) req_valid = 1'b0;
            if (res_valid) begin vcnt++; got = res_data; end
            n++;
        end
        repeat (3) begin
            @(negedge clk);
            if (res_valid) begin vcnt++; got = res_data; end
        end
        check(last_ctrl == exp_ctrl, "R3 command byte", last_ctrl, exp_ctrl);
        if (!exp_to) begin
            check(last_pulses == 24, "R6 pulses per frame", last_pulses, 24);
            check(vcnt == 1, "R7 single valid pulse", vcnt, 1);
            check(got == val, "R7 result value", got, val);
            check(res_timeout == 1'b0, "R8 no timeout", res_timeout, 0);
            check(last_gap == 14 * DIV, "R4 sclk period", last_gap, 14 * DIV);
        end else begin
            check(res_timeout == 1'b1, "R8 timeout flagged", res_timeout, 1);
            check(vcnt == 0, "R8 no valid on timeout", vcnt, 0);
            check(last_pulses == 8, "R8 no readback pulses", last_pulses, 8);
            while (!adc_sstrb) @(negedge clk);
            repeat (10) @(negedge clk);
            check(res_timeout == 1'b1, "R9 flag sticky while idle", res_timeout, 1);
            check(adc_cs_n == 1'b1 && req_ready, "R8 released", adc_cs_n, 1);
        end
        check(viol == 0, "R5 sclk low while busy", viol, 0);
        if (poke) begin
            repeat (50) @(negedge clk);
            check(frames == f0 + 1, "R2 busy request ignored", frames - f0, 1);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset/idle state
        check(adc_cs_n && !adc_sclk && !adc_din && req_ready && !res_valid && !res_timeout,
              "R1 idle state",
              {adc_cs_n, adc_sclk, adc_din, req_ready, res_valid, res_timeout}, 6'b100100);
        // directed data corners (R6/R7)
        do_frame(3'd0, 1'b1, 1'b1, 2'b11, 12'h000, 20, 1'b0);
        do_frame(3'd7, 1'b0, 1'b0, 2'b00, 12'hFFF, 40, 1'b0);
        do_frame(3'd5, 1'b1, 1'b0, 2'b01, 12'h800, 15, 1'b0);
        do_frame(3'd2, 1'b0, 1'b1, 2'b10, 12'h001, 60, 1'b0);
        // R2 request during busy frame
        do_frame(3'd3, 1'b1, 1'b1, 2'b01, 12'hA5C, 30, 1'b1);
        // R8 boundary: just inside, then beyond the limit
        do_frame(3'd6, 1'b0, 1'b1, 2'b11, 12'h3C7, 290, 1'b0);
        do_frame(3'd1, 1'b1, 1'b0, 2'b10, 12'h555, 320, 1'b0);
        // R9 next request clears and completes
        do_frame(3'd4, 1'b1, 1'b1, 2'b00, 12'h9E1, 25, 1'b0);
        do_frame(3'd4, 1'b0, 1'b0, 2'b01, 12'h123, 600, 1'b0);
        // random traffic
        for (int i = 0; i < 40; i++) begin
            do_frame(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                     12'($urandom_range(0, 4095)), $urandom_range(10, 250), 1'b0);
        end
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule